// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This unit keeps the 8-bit floating-point control and status word of a processor core. The low five bits accumulate exception flags and the top three bits hold the dynamic rounding mode. Software sees the one physical word through three CSR addresses. One address exposes only the flags, one exposes only the rounding mode, and one exposes the whole word. A write through each address changes only the bits that its view covers.

A second, narrower port faces the floating-point datapath. The datapath raises exception flags there, and they are ORed into the word. The same port continuously presents the current rounding mode. A CSR access is a single-cycle request. Read data and an error pulse come back from registers one cycle later.

Top module: `fp_status_csr`

## Requirements
- R1: During and after synchronous reset the word is zero, so `rm_out`, `csr_rdata` and `csr_err` are all zero.
- R2: A request to address 0x001 returns word bits 4:0 in `csr_rdata[4:0]`, with every higher bit zero, one cycle after the request.
- R3: A request to address 0x002 returns word bits 7:5 in `csr_rdata[2:0]`, with every higher bit zero, one cycle after the request.
- R4: A request to address 0x003 returns the whole word in `csr_rdata[7:0]`, with all bits above 7 zero.
- R5: A write to 0x001 replaces word bits 4:0 with `csr_wdata[4:0]` and leaves bits 7:5 unchanged.
- R6: A write to 0x002 replaces word bits 7:5 with `csr_wdata[2:0]` and leaves bits 4:0 unchanged.
- R7: A write to 0x003 replaces the whole word with `csr_wdata[7:0]`.
- R8: A request to any other 12-bit address raises `csr_err` for one cycle and returns zero data. A write to such an address changes no bit of the word.
- R9: In every cycle where `fpu_flags_valid` is high, `fpu_flags` is ORed into word bits 4:0.
- R10: A write to 0x001 or 0x003 in the same cycle as `fpu_flags_valid` wins: the flag bits take the written value only. A write to 0x002 does not block the flag merge.
- R11: `rm_out` always equals word bits 7:5 and shows a new rounding mode in the cycle after the write.
- R12: Read data reflects the word as it was before any write or flag merge in the same cycle. In cycles without a request, `csr_rdata` and `csr_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | CSR access strobe, one access per cycle |
| csr_we | input | 1 | The access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Registered read data, valid one cycle after the request |
| csr_err | output | 1 | Registered pulse: the address was not one of the three views |
| fpu_flags_valid | input | 1 | Exception flags from the datapath are valid |
| fpu_flags | input | 5 | Exception flags to merge |
| rm_out | output | 3 | Current rounding mode |

## Verification
The assertions assume that `csr_we` only means something when `csr_req` is high. They also assume that `csr_addr` and `csr_wdata` are known values whenever a request is made. The flag-stability checks assume that the datapath does not drive `fpu_flags_valid` in the cycles those checks cover. The bench drives every input from one process at the falling edge and keeps `csr_we` low outside requests. It chooses random addresses from the three views plus a set of nearby invalid ones, such as 0x000, 0x004, 0x101 and 0xC03. This means the high address bits are exercised as well.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int unsigned FCSR_ADDR_W  = 12;
  localparam int unsigned FCSR_FLAG_W  = 5;
  localparam int unsigned FCSR_RM_W    = 3;
  localparam int unsigned FCSR_WORD_W  = FCSR_FLAG_W + FCSR_RM_W;

  localparam logic [FCSR_ADDR_W-1:0] FCSR_ADDR_FLAGS = 12'h001;
  localparam logic [FCSR_ADDR_W-1:0] FCSR_ADDR_RM    = 12'h002;
  localparam logic [FCSR_ADDR_W-1:0] FCSR_ADDR_FULL  = 12'h003;

  typedef enum logic [1:0] {
    VIEW_NONE  = 2'd0,
    VIEW_FLAGS = 2'd1,
    VIEW_RM    = 2'd2,
    VIEW_FULL  = 2'd3
  } fcsr_view_e;
endpackage

// File: rtl/fcsr_decode.sv
module fcsr_decode
  import fcsr_pkg::*;
#(
  parameter int unsigned ADDR_W = FCSR_ADDR_W,
  parameter logic [ADDR_W-1:0] A_FLAGS = FCSR_ADDR_FLAGS,
  parameter logic [ADDR_W-1:0] A_RM    = FCSR_ADDR_RM,
  parameter logic [ADDR_W-1:0] A_FULL  = FCSR_ADDR_FULL
) (
  input  logic [ADDR_W-1:0] addr,
  output fcsr_view_e        view
);
  // Full-width compare: every address bit takes part in the match.
  always_comb begin
    view = VIEW_NONE;
    if (addr == A_FLAGS)     view = VIEW_FLAGS;
    else if (addr == A_RM)   view = VIEW_RM;
    else if (addr == A_FULL) view = VIEW_FULL;
  end
endmodule

// File: rtl/fcsr_state.sv
module fcsr_state
  import fcsr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned FLAG_W = FCSR_FLAG_W,
  parameter int unsigned RM_W   = FCSR_RM_W,
  localparam int unsigned WORD_W = FLAG_W + RM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  fcsr_view_e        view,
  input  logic [XLEN-1:0]   wdata,
  input  logic              merge_en,
  input  logic [FLAG_W-1:0] merge_flags,
  output logic [WORD_W-1:0] word_q
);
  logic [FLAG_W-1:0] flags_d;
  logic [RM_W-1:0]   rm_d;
  logic [FLAG_W-1:0] flags_acc;

  // Flags raised by the datapath accumulate unless a flag-covering write lands.
  assign flags_acc = word_q[FLAG_W-1:0] | (merge_en ? merge_flags : '0);

  always_comb begin
    flags_d = flags_acc;
    rm_d    = word_q[WORD_W-1:FLAG_W];
    if (wr_en) begin
      unique case (view)
        VIEW_FLAGS: flags_d = wdata[FLAG_W-1:0];
        VIEW_RM:    rm_d    = wdata[RM_W-1:0];
        VIEW_FULL: begin
          flags_d = wdata[FLAG_W-1:0];
          rm_d    = wdata[WORD_W-1:FLAG_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= {rm_d, flags_d};
  end
endmodule

// File: rtl/fcsr_readout.sv
module fcsr_readout
  import fcsr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned FLAG_W = FCSR_FLAG_W,
  parameter int unsigned RM_W   = FCSR_RM_W,
  localparam int unsigned WORD_W = FLAG_W + RM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  fcsr_view_e        view,
  input  logic [WORD_W-1:0] word,
  output logic [XLEN-1:0]   rdata,
  output logic              err
);
  logic [XLEN-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (view)
      VIEW_FLAGS: sel[FLAG_W-1:0] = word[FLAG_W-1:0];
      VIEW_RM:    sel[RM_W-1:0]   = word[WORD_W-1:FLAG_W];
      VIEW_FULL:  sel[WORD_W-1:0] = word;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= req ? sel : '0;
      err   <= req && (view == VIEW_NONE);
    end
  end
endmodule

// File: rtl/fp_status_csr.sv
module fp_status_csr
  import fcsr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned ADDR_W = FCSR_ADDR_W,
  parameter int unsigned FLAG_W = FCSR_FLAG_W,
  parameter int unsigned RM_W   = FCSR_RM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_req,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_err,
  input  logic              fpu_flags_valid,
  input  logic [FLAG_W-1:0] fpu_flags,
  output logic [RM_W-1:0]   rm_out
);
  localparam int unsigned WORD_W = FLAG_W + RM_W;

  fcsr_view_e        view;
  logic [WORD_W-1:0] word_q;
  logic              wr_en;

  assign wr_en = csr_req && csr_we && (view != VIEW_NONE);

  fcsr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (csr_addr),
    .view (view)
  );

  fcsr_state #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_state (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .view        (view),
    .wdata       (csr_wdata),
    .merge_en    (fpu_flags_valid),
    .merge_flags (fpu_flags),
    .word_q      (word_q)
  );

  fcsr_readout #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .req   (csr_req),
    .view  (view),
    .word  (word_q),
    .rdata (csr_rdata),
    .err   (csr_err)
  );

  assign rm_out = word_q[WORD_W-1:FLAG_W];
endmodule

// File: rtl/fp_status_csr_chk.sv
module fp_status_csr_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned FLAG_W = 5,
  parameter int unsigned RM_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     csr_req,
  input logic                     csr_we,
  input logic [ADDR_W-1:0]        csr_addr,
  input logic [XLEN-1:0]          csr_wdata,
  input logic [XLEN-1:0]          csr_rdata,
  input logic                     csr_err,
  input logic                     fpu_flags_valid,
  input logic [FLAG_W-1:0]        fpu_flags,
  input logic [RM_W-1:0]          rm_out,
  input logic [FLAG_W+RM_W-1:0]   word_q
);
  localparam int unsigned WORD_W = FLAG_W + RM_W;

  logic hit_flags, hit_rm, hit_full, bad_req;
  assign hit_flags = csr_addr == ADDR_W'(1);
  assign hit_rm    = csr_addr == ADDR_W'(2);
  assign hit_full  = csr_addr == ADDR_W'(3);
  assign bad_req   = csr_req && !hit_flags && !hit_rm && !hit_full;

  assert_err_zero_data_R8: assert property (@(posedge clk) disable iff (rst)
    csr_err |-> csr_rdata == '0);

  assert_bad_write_keeps_word_R8: assert property (@(posedge clk) disable iff (rst)
    (bad_req && !fpu_flags_valid) |=> $stable(word_q));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !csr_req |=> (!csr_err && csr_rdata == '0));

  assert_rm_write_R6: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_we && hit_rm) |=> rm_out == $past(csr_wdata[RM_W-1:0]));

  assert_full_write_R7: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_we && hit_full) |=> word_q == $past(csr_wdata[WORD_W-1:0]));

  assert_rm_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(csr_req && csr_we && (hit_rm || hit_full)) |=> $stable(rm_out));

  assert_flag_merge_R9: assert property (@(posedge clk) disable iff (rst)
    (fpu_flags_valid && !(csr_req && csr_we && (hit_flags || hit_full)))
      |=> (word_q[FLAG_W-1:0] & $past(fpu_flags)) == $past(fpu_flags));

  assert_flag_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_req && csr_we && hit_flags) |=> word_q[FLAG_W-1:0] == $past(csr_wdata[FLAG_W-1:0]));

  assert_full_read_width_R4: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[XLEN-1:WORD_W] == '0);

  assert_flags_read_width_R2: assert property (@(posedge clk) disable iff (rst)
    (csr_req && hit_flags) |=> csr_rdata[XLEN-1:FLAG_W] == '0);
endmodule

bind fp_status_csr fp_status_csr_chk #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .FLAG_W(FLAG_W), .RM_W(RM_W)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .csr_req         (csr_req),
  .csr_we          (csr_we),
  .csr_addr        (csr_addr),
  .csr_wdata       (csr_wdata),
  .csr_rdata       (csr_rdata),
  .csr_err         (csr_err),
  .fpu_flags_valid (fpu_flags_valid),
  .fpu_flags       (fpu_flags),
  .rm_out          (rm_out),
  .word_q          (word_q)
);

// File: tb/fp_status_csr_test.sv
`timescale 1ns/1ps
module fp_status_csr_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            csr_req = 1'b0;
  logic            csr_we = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic            csr_err;
  logic            fpu_flags_valid = 1'b0;
  logic [4:0]      fpu_flags = '0;
  logic [2:0]      rm_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Behavioural model state
  int unsigned m_word = 0;
  int unsigned exp_rdata = 0;
  bit          exp_err = 0;

  always #2 clk = ~clk;

  fp_status_csr #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .csr_err(csr_err), .fpu_flags_valid(fpu_flags_valid),
    .fpu_flags(fpu_flags), .rm_out(rm_out)
  );

  task automatic compare(input string tag);
    checks++;
    if (csr_rdata !== exp_rdata || csr_err !== exp_err || rm_out !== 3'(m_word >> 5)) begin
      errors++;
      $display("FAIL %s: rdata=%h err=%0b rm=%0d expected rdata=%h err=%0b rm=%0d",
               tag, csr_rdata, csr_err, rm_out, exp_rdata, exp_err, (m_word >> 5) & 7);
    end
  endtask

  // Apply one cycle of stimulus, advance the model, compare after the edge.
  task automatic step(input bit req, input bit we, input int unsigned addr,
                      input int unsigned wd, input bit fv, input int unsigned ff,
                      input string tag);
    int unsigned nxt;
    csr_req = req; csr_we = we; csr_addr = 12'(addr); csr_wdata = wd;
    fpu_flags_valid = fv; fpu_flags = 5'(ff);
    exp_rdata = 0; exp_err = 0;
    if (req) begin
      if (addr == 1)      exp_rdata = m_word & 32'h1f;
      else if (addr == 2) exp_rdata = (m_word >> 5) & 32'h7;
      else if (addr == 3) exp_rdata = m_word & 32'hff;
      else                exp_err = 1;
    end
    nxt = m_word;
    if (fv) nxt = nxt | (ff & 32'h1f);
    if (req && we) begin
      if (addr == 1)      nxt = (nxt & 32'he0) | (wd & 32'h1f);
      else if (addr == 2) nxt = (nxt & 32'h1f) | ((wd & 32'h7) << 5);
      else if (addr == 3) nxt = wd & 32'hff;
    end
    m_word = nxt;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    csr_req = 0; csr_we = 0; fpu_flags_valid = 0;
  endtask

  function automatic int unsigned pick_addr(input int unsigned r);
    case (r % 8)
      0: return 1; 1: return 2; 2: return 3; 3: return 3;
      4: return 0; 5: return 4; 6: return 12'h101;
      default: return 12'hC03;
    endcase
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst = 0;
    step(0, 0, 0, 0, 0, 0, "R1 after reset idle");
    step(1, 0, 3, 0, 0, 0, "R1 full read zero");

    step(1, 1, 3, 32'hFFFF_FFA5, 0, 0, "R7 full write");
    step(1, 0, 3, 0, 0, 0, "R4 full read");
    step(1, 0, 1, 0, 0, 0, "R2 flags read");
    step(1, 0, 2, 0, 0, 0, "R3 rm read");

    step(1, 1, 1, 32'hFFFF_FFEA, 0, 0, "R5 flags write");
    step(1, 0, 3, 0, 0, 0, "R5 rm kept");
    step(1, 1, 2, 32'hFFFF_FFF3, 0, 0, "R6 rm write");
    step(1, 0, 3, 0, 0, 0, "R6 flags kept");
    step(0, 0, 0, 0, 0, 0, "R11 rm output");

    step(1, 1, 12'h004, 32'hFF, 0, 0, "R8 bad write err");
    step(1, 1, 12'hC03, 32'h00, 0, 0, "R8 high bits decoded");
    step(1, 0, 3, 0, 0, 0, "R8 word unchanged");

    step(1, 1, 3, 0, 0, 0, "R7 clear");
    step(0, 0, 0, 0, 1, 5'b00101, "R9 merge a");
    step(0, 0, 0, 0, 1, 5'b10000, "R9 merge b");
    step(1, 0, 1, 0, 0, 0, "R9 accumulated");

    step(1, 1, 1, 32'h2, 1, 5'b11000, "R10 flag write wins");
    step(1, 1, 2, 32'h5, 1, 5'b01000, "R10 rm write keeps merge");
    step(1, 0, 3, 0, 0, 0, "R10 readback");

    step(1, 1, 3, 32'h1F, 1, 5'b00001, "R12 read before write");
    step(1, 0, 3, 0, 0, 0, "R12 new value");

    for (int i = 0; i < 400; i++) begin
      int unsigned r1 = $urandom;
      int unsigned r2 = $urandom;
      bit rq = r1[0] | r1[1];
      step(rq, rq & r1[2], pick_addr(r1 >> 4), r2, r1[3], r1 >> 12, "R9 R10 R12 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule